// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural state update that a small 32-bit processor makes when it takes an exception. The pipeline presents a one-cycle request with a 3-bit type code, the current program counter, the interrupt-enable register and the remap control bit. The block then picks the exception class. It writes the return address into the link register that belongs to that class and updates the enable bits. It also computes the handler entry point from one of two vector base registers.

There are two classes. The debug class covers breakpoint and watchpoint. The normal class covers the two bus errors, divide by zero, external interrupt and system call. Each class has its own return-address register and its own saved-enable bit. The entry point is the selected base plus the type code times 32. Every output is registered. Each write strobe and the redirect strobe last one cycle and appear in the cycle after the request. A type code with no handler leaves all state untouched and raises an error pulse instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero in the following cycle.
- R2: Type codes 2, 4, 5, 6 and 7 are normal exceptions and raise `eaWe` only. Codes 1 and 3 are debug exceptions and raise `baWe` only.
- R3: On an accepted exception, `linkData` carries the `curPc` value that was present with the request.
- R4: The enable register has three bits: bit 0 is the global enable, bit 1 is the normal saved-enable and bit 2 is the debug saved-enable. A normal exception writes it (`ieWe`) with bit 0 cleared, bit 1 ORed with the old bit 0, and bit 2 unchanged.
- R5: A debug exception writes the enable register with bit 0 cleared, bit 2 ORed with the old bit 0, and bit 1 unchanged.
- R6: `redirectPc` equals the selected base plus the type code times 32. The bases are 256-byte aligned, so the upper 24 bits come from the base and bits 7:5 hold the code.
- R7: A normal exception uses `normBase` when `remapEn` is 0 and `dbgBase` when `remapEn` is 1.
- R8: A debug exception always uses `dbgBase`, whatever the value of `remapEn`.
- R9: Type code 0 is unhandled. It raises `unhandledErr` for one cycle. It raises none of `eaWe`, `baWe`, `ieWe` or `redirectValid`.
- R10: `redirectValid`, `ieWe` and the link strobe are high only in the cycle after a request cycle. When there is no request, they stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| excReq | input | 1 | Exception request, one cycle per exception |
| excCode | input | 3 | Exception type code |
| curPc | input | 32 | Program counter of the faulting instruction |
| ieIn | input | 3 | Current enable register {debug saved, normal saved, global} |
| remapEn | input | 1 | Send normal exceptions to the debug base |
| normBase | input | 32 | Normal vector base |
| dbgBase | input | 32 | Debug vector base |
| eaWe | output | 1 | Write strobe for the normal return-address register |
| baWe | output | 1 | Write strobe for the debug return-address register |
| linkData | output | 32 | Return address to write |
| ieWe | output | 1 | Write strobe for the enable register |
| ieOut | output | 3 | New enable register value |
| redirectValid | output | 1 | Fetch redirect strobe |
| redirectPc | output | 32 | Handler entry address |
| unhandledErr | output | 1 | Unhandled type code pulse |

## Verification
The bench sweeps all eight type codes. For each code it tries all eight enable-register values and both remap settings, with two pairs of vector bases and several program counters. This lets it tell the normal path from the debug path, the base selected by remap from the one that ignores remap, and a saved-enable bit ORed in from one that is overwritten. The old-enable values of 0 and 1 show whether the global bit was sampled before it was cleared. Idle cycles between requests, and a pair of back-to-back requests, show that the strobes last exactly one cycle. Code 0 checks that nothing is written.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 3;

  // enable register bit positions
  localparam int IE_GLB  = 0;
  localparam int IE_SAVN = 1;
  localparam int IE_SAVD = 2;
  localparam int IE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_BRKPT = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIVZ  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } excCode_e;

  // strobes from classification to the datapath
  typedef struct packed {
    logic takeNorm;
    logic takeDbg;
    logic useDbgBase;
    logic flagBad;
  } entryCtl_t;

endpackage

// File: rtl/exc_entry_classify.sv
module exc_entry_classify
  import exc_entry_pkg::*;
(
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              remapEn,
  output entryCtl_t         ctl
);

  logic isDbg;
  logic isNorm;

  always_comb begin
    isDbg  = 1'b0;
    isNorm = 1'b0;
    case (excCode_e'(excCode))
      EXC_BRKPT, EXC_WATCH:                       isDbg  = 1'b1;
      EXC_IBUS, EXC_DBUS, EXC_DIVZ, EXC_IRQ, EXC_SCALL: isNorm = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    ctl.takeNorm   = excReq & isNorm;
    ctl.takeDbg    = excReq & isDbg;
    ctl.useDbgBase = isDbg | remapEn;
    ctl.flagBad    = excReq & ~isNorm & ~isDbg;
  end

endmodule

// File: rtl/exc_entry_datapath.sv
module exc_entry_datapath
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  entryCtl_t         ctl,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [IE_W-1:0]   ieIn,
  input  logic [ADDR_W-1:0] normBase,
  input  logic [ADDR_W-1:0] dbgBase,
  output logic              eaWe,
  output logic              baWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              ieWe,
  output logic [IE_W-1:0]   ieOut,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              unhandledErr
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = (ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1);

  logic              takeAny;
  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] slotOfs;
  logic [ADDR_W-1:0] target;
  logic [IE_W-1:0]   ieNext;

  assign takeAny = ctl.takeNorm | ctl.takeDbg;
  assign selBase = ctl.useDbgBase ? dbgBase : normBase;
  assign slotOfs = ADDR_W'(excCode) << SLOT_SHIFT;
  // aligned base: low bits are free, so an OR replaces the adder
  assign target  = (selBase & ~ALIGN_MASK) | slotOfs;

  always_comb begin
    ieNext          = ieIn;
    ieNext[IE_GLB]  = 1'b0;
    ieNext[IE_SAVN] = ieIn[IE_SAVN] | (ctl.takeNorm & ieIn[IE_GLB]);
    ieNext[IE_SAVD] = ieIn[IE_SAVD] | (ctl.takeDbg  & ieIn[IE_GLB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eaWe          <= 1'b0;
      baWe          <= 1'b0;
      ieWe          <= 1'b0;
      redirectValid <= 1'b0;
      unhandledErr  <= 1'b0;
      linkData      <= '0;
      ieOut         <= '0;
      redirectPc    <= '0;
    end else begin
      eaWe          <= ctl.takeNorm;
      baWe          <= ctl.takeDbg;
      ieWe          <= takeAny;
      redirectValid <= takeAny;
      unhandledErr  <= ctl.flagBad;
      if (takeAny) begin
        linkData   <= curPc;
        ieOut      <= ieNext;
        redirectPc <= target;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excReq,
  input  logic [2:0]        excCode,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [2:0]        ieIn,
  input  logic              remapEn,
  input  logic [ADDR_W-1:0] normBase,
  input  logic [ADDR_W-1:0] dbgBase,
  output logic              eaWe,
  output logic              baWe,
  output logic [ADDR_W-1:0] linkData,
  output logic              ieWe,
  output logic [2:0]        ieOut,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              unhandledErr
);

  entryCtl_t ctl;

  exc_entry_classify u_cls (
    .excReq  (excReq),
    .excCode (excCode),
    .remapEn (remapEn),
    .ctl     (ctl)
  );

  exc_entry_datapath #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .ctl           (ctl),
    .excCode       (excCode),
    .curPc         (curPc),
    .ieIn          (ieIn),
    .normBase      (normBase),
    .dbgBase       (dbgBase),
    .eaWe          (eaWe),
    .baWe          (baWe),
    .linkData      (linkData),
    .ieWe          (ieWe),
    .ieOut         (ieOut),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .unhandledErr  (unhandledErr)
  );

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              excReq,
  input logic [2:0]        excCode,
  input logic [ADDR_W-1:0] curPc,
  input logic [2:0]        ieIn,
  input logic              remapEn,
  input logic [ADDR_W-1:0] normBase,
  input logic [ADDR_W-1:0] dbgBase,
  input logic              eaWe,
  input logic              baWe,
  input logic [ADDR_W-1:0] linkData,
  input logic              ieWe,
  input logic [2:0]        ieOut,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc,
  input logic              unhandledErr
);

  a_r2_one_link: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> (eaWe ^ baWe));

  a_r3_link_pc: assert property (@(posedge clk) disable iff (rst)
    (eaWe || baWe) |-> linkData == $past(curPc));

  a_r4_glb_clear: assert property (@(posedge clk) disable iff (rst)
    ieWe |-> !ieOut[0]);

  a_r4_saved_norm: assert property (@(posedge clk) disable iff (rst)
    (eaWe && $past(ieIn[0])) |-> ieOut[1]);

  a_r5_saved_dbg: assert property (@(posedge clk) disable iff (rst)
    (baWe && $past(ieIn[0])) |-> ieOut[2]);

  a_r6_slot: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> (redirectPc[7:5] == $past(excCode) && redirectPc[4:0] == 5'd0));

  a_r7_norm_base: assert property (@(posedge clk) disable iff (rst)
    (eaWe && !$past(remapEn)) |->
      redirectPc[ADDR_W-1:ALIGN_BITS] == $past(normBase[ADDR_W-1:ALIGN_BITS]));

  a_r8_dbg_base: assert property (@(posedge clk) disable iff (rst)
    baWe |-> redirectPc[ADDR_W-1:ALIGN_BITS] == $past(dbgBase[ADDR_W-1:ALIGN_BITS]));

  a_r9_no_state: assert property (@(posedge clk) disable iff (rst)
    unhandledErr |-> (!redirectValid && !ieWe && !eaWe && !baWe));

  a_r9_cause: assert property (@(posedge clk) disable iff (rst)
    unhandledErr |-> ($past(excReq) && $past(excCode) == 3'd0));

  a_r10_after_req: assert property (@(posedge clk) disable iff (rst)
    (redirectValid || ieWe) |-> $past(excReq));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .ALIGN_BITS (ALIGN_BITS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .excReq        (excReq),
  .excCode       (excCode),
  .curPc         (curPc),
  .ieIn          (ieIn),
  .remapEn       (remapEn),
  .normBase      (normBase),
  .dbgBase       (dbgBase),
  .eaWe          (eaWe),
  .baWe          (baWe),
  .linkData      (linkData),
  .ieWe          (ieWe),
  .ieOut         (ieOut),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .unhandledErr  (unhandledErr)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        excReq = 1'b0;
  logic [2:0]  excCode = '0;
  logic [31:0] curPc = '0;
  logic [2:0]  ieIn = '0;
  logic        remapEn = 1'b0;
  logic [31:0] normBase = '0;
  logic [31:0] dbgBase = '0;
  logic        eaWe, baWe, ieWe, redirectValid, unhandledErr;
  logic [31:0] linkData, redirectPc;
  logic [2:0]  ieOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst(rst), .excReq(excReq), .excCode(excCode), .curPc(curPc),
    .ieIn(ieIn), .remapEn(remapEn), .normBase(normBase), .dbgBase(dbgBase),
    .eaWe(eaWe), .baWe(baWe), .linkData(linkData), .ieWe(ieWe), .ieOut(ieOut),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .unhandledErr(unhandledErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, {28'd0, eaWe, baWe, ieWe, redirectValid}, 32'd0);
    check(req, {31'd0, unhandledErr}, 32'd0);
  endtask

  // drive one request at a falling edge, check after the next rising edge
  task automatic runOne(input logic [2:0] code, input logic [2:0] ie, input logic rm,
                        input logic [31:0] nb, input logic [31:0] db, input logic [31:0] pc,
                        input bit idleAfter);
    bit isDbg, isBad;
    logic [31:0] base, expPc;
    logic [2:0] expIe;
    isDbg = (code == 3'd1) || (code == 3'd3);
    isBad = (code == 3'd0);
    base  = (isDbg || rm) ? db : nb;
    expPc = base + 32'(code) * 32;
    expIe = {ie[2] | (isDbg & ie[0]), ie[1] | (!isDbg & ie[0]), 1'b0};
    excReq = 1'b1; excCode = code; ieIn = ie; remapEn = rm;
    normBase = nb; dbgBase = db; curPc = pc;
    @(negedge clk);
    if (idleAfter) excReq = 1'b0;
    if (isBad) begin
      check("R9 err", {31'd0, unhandledErr}, 32'd1);
      check("R9 no write", {28'd0, eaWe, baWe, ieWe, redirectValid}, 32'd0);
    end else begin
      check("R2 class", {30'd0, eaWe, baWe}, isDbg ? 32'd1 : 32'd2);
      check("R3 link", linkData, pc);
      check(isDbg ? "R5 ie" : "R4 ie", {28'd0, ieWe, ieOut}, {28'd1, expIe});
      check(rm ? "R7 remap / R8 dbg" : (isDbg ? "R8 dbg" : "R7 norm / R6 addr"),
            redirectPc, expPc);
      check("R10 strobe", {30'd0, redirectValid, unhandledErr}, 32'd2);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] nbs [2];
    logic [31:0] dbs [2];
    nbs[0] = 32'h0000_0000; dbs[0] = 32'hFFFF_FF00;
    nbs[1] = 32'h1234_5600; dbs[1] = 32'h8000_0100;
    // R1: outputs during reset even with a request present
    excReq = 1'b1; excCode = 3'd6; ieIn = 3'd1; curPc = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R1 strobes", {27'd0, eaWe, baWe, ieWe, redirectValid, unhandledErr}, 32'd0);
    check("R1 data", linkData | redirectPc | {29'd0, ieOut}, 32'd0);
    excReq = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R10 idle after reset");

    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 8; c++)
        for (int e = 0; e < 8; e++)
          for (int r = 0; r < 2; r++) begin
            runOne(3'(c), 3'(e), 1'(r), nbs[b], dbs[b],
                   32'h0100_0000 ^ (32'(c) << 12) ^ (32'(e) << 4) ^ (32'(b) << 28) ^ 32'(r * 4),
                   1'b1);
            @(negedge clk);
            checkIdle("R10 one cycle");
          end

    // back-to-back: interrupt then breakpoint, then unhandled
    runOne(3'd6, 3'd1, 1'b0, nbs[1], dbs[1], 32'hA000_0010, 1'b0);
    runOne(3'd1, 3'd3, 1'b0, nbs[1], dbs[1], 32'hA000_0020, 1'b0);
    runOne(3'd0, 3'd1, 1'b1, nbs[1], dbs[1], 32'hA000_0030, 1'b1);
    @(negedge clk);
    checkIdle("R10 after burst");
    check("R9 data held", linkData, 32'hA000_0020);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule